// File: doc/BRIEF.md
# Dual-Lane Serial Frame Receiver

This block takes event packets arriving on two serial data lines that share one serial clock. It samples all three lines with a faster system clock. Packet boundaries are marked in-band. While the serial clock is held high, a burst of rising edges on the first data line opens a packet. The same kind of burst on the second data line closes it.

Inside a packet, 10-bit words arrive on both lanes at once. The second lane runs five bit times behind the first. Each word becomes one 18-bit record on a FIFO write port. The record carries a parity-fault flag for that word and three sticky framing flags for the packet. The framing flags cover a short packet, a long packet and a repeated opening marker.

Downstream logic only has to store the records. The bit-11 closing record tells it that a packet was cut short. The flags tell it which records to distrust.

Top module: `dual_lane_frame_rx`

## Requirements
- R1: A packet opens only when the first data line shows four rising edges within one high period of the serial clock. A low serial clock clears the edge count, so bursts of three split by a low phase open nothing and the words that follow produce no record.
- R2: Four rising edges on the second data line, within one high period of the serial clock, close an open packet. A closing burst while no packet is open writes no record.
- R3: Bits are taken at each serial clock rising edge, most significant bit first. The first lane carries words 1, 3, 5 and so on. The second lane carries words 2, 4, 6 and so on, and its first bit comes on the sixth rising edge after the opening marker. Every word gives exactly one write, in arrival order, with the word in record bits 9:0.
- R4: Record bit 10 is set when the XOR of the ten word bits is 0, meaning odd parity failed. Otherwise bit 10 is clear.
- R5: A packet closed after fewer than 263 words ends with one extra record. That record has bits 9:0 zero, bit 10 clear and bit 11 set.
- R6: The 264th word of a packet and every word after it carry bit 12.
- R7: An opening marker inside an open packet restarts the word count and lane alignment and drops any partial words. Bit 13 is then set on every later record of that packet, the closing record included.
- R8: An opening marker while no packet is open clears bits 12 and 13. Record bits 17:14 are always zero.
- R9: While reset is held and after its release, no write occurs until words arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial clock shared by both lanes |
| lane1_in | input | 1 | First serial lane: opening marker and odd words |
| lane2_in | input | 1 | Second serial lane: closing marker and even words |
| fifo_wr | output | 1 | One-cycle write strobe per record |
| fifo_data | output | 18 | Record: word, parity flag, framing flags |

## Verification
A serial clock rising edge passes two synchronizer stages and an edge register, then the lane deserializer, then the record register. The write for a finished word is therefore on `fifo_wr` after the fourth system clock rising edge. The closing record follows the fourth closing edge with a similar short delay. The bench does not sample at fixed offsets. It logs every write on the falling edge of the system clock, then waits thirty cycles after each closing marker before comparing the log against a queue built from the words it sent. In this way both a missing record and an extra record are counted, and so are a late record and a wrong field.

// File: rtl/dlfr_pkg.sv
package dlfr_pkg;
  localparam int WORD_W   = 10;
  localparam int REC_W    = 18;
  localparam int PERR_BIT = 10;
  localparam int UFL_BIT  = 11;
  localparam int OVF_BIT  = 12;
  localparam int DBL_BIT  = 13;

  // odd parity over the whole word: even number of ones is a fault
  function automatic logic parity_bad(input logic [WORD_W-1:0] w);
    return ~(^w);
  endfunction

  function automatic logic [REC_W-1:0] make_record(
    input logic [WORD_W-1:0] w,
    input logic perr,
    input logic ufl,
    input logic ovf,
    input logic dbl
  );
    logic [REC_W-1:0] r;
    r = '0;
    r[WORD_W-1:0] = w;
    r[PERR_BIT]   = perr;
    r[UFL_BIT]    = ufl;
    r[OVF_BIT]    = ovf;
    r[DBL_BIT]    = dbl;
    return r;
  endfunction
endpackage

// File: rtl/dlfr_sync.sv
module dlfr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dlfr_marker.sv
module dlfr_marker #(
  parameter int EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_hi,
  input  logic edge_in,
  output logic fire
);
  localparam int CW = $clog2(EDGES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !sclk_hi) cnt <= '0;
    else if (edge_in && cnt != CW'(EDGES)) cnt <= cnt + 1'b1;
  end

  assign fire = sclk_hi && edge_in && (cnt == CW'(EDGES - 1));

  // earlier edges of the burst required the clock to be high already
  assert_marker_in_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(sclk_hi));
endmodule

// File: rtl/dlfr_lane.sv
module dlfr_lane import dlfr_pkg::*; #(
  parameter int SKEW = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic              sample,
  input  logic              din,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int SK_W = $clog2(SKEW + 2);
  localparam int BC_W = $clog2(WORD_W);

  logic [SK_W-1:0]   skip;
  logic [BC_W-1:0]   bit_cnt;
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip <= '0; bit_cnt <= '0; sh <= '0; done <= 1'b0; word <= '0;
    end else if (restart) begin
      skip <= SK_W'(SKEW); bit_cnt <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (active && sample) begin
        if (skip != '0) begin
          skip <= skip - 1'b1;
        end else begin
          sh <= {sh[WORD_W-2:0], din};
          if (bit_cnt == BC_W'(WORD_W - 1)) begin
            bit_cnt <= '0;
            done    <= 1'b1;
            word    <= {sh[WORD_W-2:0], din};
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  assert_done_spaced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/dual_lane_frame_rx.sv
module dual_lane_frame_rx import dlfr_pkg::*; #(
  parameter int PKT_WORDS   = 263,
  parameter int LANE_SKEW   = 5,
  parameter int MARK_EDGES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             lane1_in,
  input  logic             lane2_in,
  output logic             fifo_wr,
  output logic [REC_W-1:0] fifo_data
);
  localparam int CNT_W   = $clog2(PKT_WORDS + 2);
  localparam int CNT_MAX = PKT_WORDS + 1;

  logic [2:0] s_bus;
  logic       s_sclk, sclk_q, sclk_rise;
  logic [1:0] lane_s, lane_q, lane_rise;

  dlfr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_clk, lane2_in, lane1_in}), .q(s_bus));

  assign s_sclk = s_bus[2];
  assign lane_s = s_bus[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; lane_q <= '0;
    end else begin
      sclk_q <= s_sclk; lane_q <= lane_s;
    end
  end

  assign sclk_rise = s_sclk & ~sclk_q;
  assign lane_rise = lane_s & ~lane_q;

  logic              in_pkt, ovf_flag, dbl_flag;
  logic [CNT_W-1:0]  word_cnt;
  logic [1:0]        mark_fire, word_done;
  logic [WORD_W-1:0] lane_word [2];
  logic              start_ev, stop_ev, ufl_wr, any_done, over_now, wr_next;
  logic [WORD_W-1:0] sel_word;
  logic [REC_W-1:0]  rec_next;

  assign start_ev = mark_fire[0];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dlfr_marker #(.EDGES(MARK_EDGES)) u_mark (
      .clk(clk), .rst_n(rst_n), .sclk_hi(s_sclk),
      .edge_in(lane_rise[g]), .fire(mark_fire[g]));
    dlfr_lane #(.SKEW(g * LANE_SKEW)) u_lane (
      .clk(clk), .rst_n(rst_n), .restart(start_ev), .active(in_pkt),
      .sample(sclk_rise), .din(lane_s[g]), .done(word_done[g]),
      .word(lane_word[g]));
  end

  assign stop_ev  = mark_fire[1] && in_pkt;
  assign ufl_wr   = stop_ev && (word_cnt < CNT_W'(PKT_WORDS));
  assign any_done = |word_done;
  assign sel_word = word_done[1] ? lane_word[1] : lane_word[0];
  assign over_now = any_done && (word_cnt >= CNT_W'(PKT_WORDS));
  assign wr_next  = any_done || ufl_wr;

  always_comb begin
    if (any_done)
      rec_next = make_record(sel_word, parity_bad(sel_word), 1'b0,
                             ovf_flag | over_now, dbl_flag);
    else
      rec_next = make_record('0, 1'b0, ufl_wr, ovf_flag, dbl_flag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0; word_cnt <= '0; ovf_flag <= 1'b0; dbl_flag <= 1'b0;
      fifo_wr <= 1'b0; fifo_data <= '0;
    end else begin
      fifo_wr <= wr_next;
      if (wr_next) fifo_data <= rec_next;
      if (start_ev) in_pkt <= 1'b1;
      else if (stop_ev) in_pkt <= 1'b0;
      if (start_ev) word_cnt <= '0;
      else if (any_done && word_cnt != CNT_W'(CNT_MAX)) word_cnt <= word_cnt + 1'b1;
      if (start_ev && !in_pkt) ovf_flag <= 1'b0;
      else if (over_now) ovf_flag <= 1'b1;
      if (start_ev && !in_pkt) dbl_flag <= 1'b0;
      else if (start_ev) dbl_flag <= 1'b1;
    end
  end

  assert_single_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_done, ufl_wr}));
  assert_parity_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !fifo_data[UFL_BIT]) |-> (fifo_data[PERR_BIT] == ~(^fifo_data[WORD_W-1:0])));
  assert_closing_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ufl_wr |=> (fifo_wr && fifo_data[UFL_BIT] && fifo_data[WORD_W-1:0] == '0));
  assert_overflow_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
    over_now |=> (fifo_wr && fifo_data[OVF_BIT]));
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && $past(in_pkt) && $past(ovf_flag)) |-> ovf_flag);
  assert_high_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_data[REC_W-1:DBL_BIT+1] == '0));
endmodule

// File: tb/dual_lane_frame_rx_tb.sv
module dual_lane_frame_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, la = 1'b0, lb = 1'b0;
  logic fifo_wr;
  logic [17:0] fifo_data;

  int checks = 0;
  int errors = 0;
  logic [17:0] got[$];
  logic [17:0] exp_q[$];
  logic [9:0]  ws[$];

  always #10 clk = ~clk;

  dual_lane_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .lane1_in(la), .lane2_in(lb),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data));

  always @(negedge clk) if (rst_n && fifo_wr) got.push_back(fifo_data);

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired (R9 run end) actual=hung expected=done");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [17:0] exp_rec(input logic [9:0] w, input bit perr,
                                          input bit ufl, input bit ovf, input bit dbl);
    logic [17:0] r;
    r = {4'b0000, dbl, ovf, ufl, perr, w};
    return r;
  endfunction

  function automatic logic [9:0] gen_word(input bit bad);
    logic [9:0] w;
    w[8:0] = 9'($urandom);
    w[9] = ~(^w[8:0]);
    if (bad) w[9] = ~w[9];
    return w;
  endfunction

  // nedges rising edges on the chosen lane during one high serial clock phase
  task automatic marker(input bit on_second, input int nedges);
    sclk = 1'b0; la = 1'b0; lb = 1'b0; tick(4);
    sclk = 1'b1; tick(4);
    for (int k = 0; k < nedges; k++) begin
      if (on_second) lb = 1'b1; else la = 1'b1;
      tick(3);
      la = 1'b0; lb = 1'b0;
      tick(3);
    end
    sclk = 1'b0; tick(4);
  endtask

  task automatic send_words();
    int n, na, nb, tt, tb_i;
    n = ws.size(); na = (n + 1) / 2; nb = n / 2;
    tt = 10 * na;
    if (nb > 0 && 5 + 10 * nb > tt) tt = 5 + 10 * nb;
    for (int t = 0; t < tt; t++) begin
      sclk = 1'b0;
      la = (t < 10 * na) ? ws[2 * (t / 10)][9 - (t % 10)] : 1'b0;
      tb_i = t - 5;
      lb = (t >= 5 && tb_i < 10 * nb) ? ws[2 * (tb_i / 10) + 1][9 - (tb_i % 10)] : 1'b0;
      tick(4);
      sclk = 1'b1;
      tick(4);
    end
    sclk = 1'b0; la = 1'b0; lb = 1'b0; tick(4);
  endtask

  task automatic expect_words(input bit dbl);
    for (int i = 0; i < ws.size(); i++)
      exp_q.push_back(exp_rec(ws[i], ~(^ws[i]), 1'b0, i >= 263, dbl));
  endtask

  task automatic fill(input int n, input int bad_pct);
    ws.delete();
    for (int i = 0; i < n; i++) ws.push_back(gen_word(($urandom % 100) < bad_pct));
  endtask

  task automatic check_pkt(input string tag);
    tick(30);
    checks++;
    if (got.size() != exp_q.size()) begin
      errors++;
      $display("FAIL %s record count actual=%0d expected=%0d", tag, got.size(), exp_q.size());
    end
    for (int i = 0; i < got.size() && i < exp_q.size(); i++) begin
      checks++;
      if (got[i] !== exp_q[i]) begin
        errors++;
        $display("FAIL %s record %0d actual=%h expected=%h", tag, i, got[i], exp_q[i]);
      end
    end
    got.delete(); exp_q.delete();
  endtask

  initial begin
    void'($urandom(32'h5eed));
    tick(5);
    checks++;
    if (fifo_wr !== 1'b0) begin
      errors++; $display("FAIL R9 write during reset actual=%b expected=0", fifo_wr);
    end
    rst_n = 1'b1; tick(10);
    check_pkt("R9");

    // closing marker while idle: nothing written
    marker(1'b1, 4);
    check_pkt("R2");

    // two three-edge bursts split by a low phase: no packet opens
    marker(1'b0, 3); marker(1'b0, 3);
    fill(4, 0); send_words(); marker(1'b1, 4);
    check_pkt("R1");

    // full packet, clean parity
    marker(1'b0, 4); fill(263, 0); send_words(); marker(1'b1, 4);
    expect_words(1'b0);
    check_pkt("R3");

    // full packet, random parity faults
    marker(1'b0, 4); fill(263, 15); send_words(); marker(1'b1, 4);
    expect_words(1'b0);
    check_pkt("R4");

    // short packet: closing record
    marker(1'b0, 4); fill(7, 20); send_words(); marker(1'b1, 4);
    expect_words(1'b0);
    exp_q.push_back(exp_rec(10'h000, 1'b0, 1'b1, 1'b0, 1'b0));
    check_pkt("R5");

    // long packet: words past 263 flagged
    marker(1'b0, 4); fill(266, 10); send_words(); marker(1'b1, 4);
    expect_words(1'b0);
    check_pkt("R6");

    // repeated opening marker mid-packet
    marker(1'b0, 4); fill(3, 0); send_words(); expect_words(1'b0);
    marker(1'b0, 4); fill(6, 30); send_words(); expect_words(1'b1);
    marker(1'b1, 4);
    exp_q.push_back(exp_rec(10'h000, 1'b0, 1'b1, 1'b0, 1'b1));
    check_pkt("R7");

    // fresh packet after that: flags cleared
    marker(1'b0, 4); fill(2, 0); send_words(); marker(1'b1, 4);
    expect_words(1'b0);
    exp_q.push_back(exp_rec(10'h000, 1'b0, 1'b1, 1'b0, 1'b0));
    check_pkt("R8");

    // directed corner: single word, all-zero word (parity fault)
    marker(1'b0, 4); ws.delete(); ws.push_back(10'h000); send_words(); marker(1'b1, 4);
    expect_words(1'b0);
    exp_q.push_back(exp_rec(10'h000, 1'b0, 1'b1, 1'b0, 1'b0));
    check_pkt("R4");

    finish_run();
  end
endmodule